// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Decoder

This block acts as the receiving host on a two-wire keyboard link. It samples the keyboard clock and data lines in the system clock domain, assembles each 11-bit frame on the falling edges of the keyboard clock, and checks the parity and stop bits. The resulting byte stream passes through a prefix-tracking state machine. Each key press or release comes out as one typed event: the scan code, an extended flag and a release flag, marked by a one-cycle valid strobe.

The extended prefix (0xE0) and the release prefix (0xF0) are absorbed and never reported as events. The two prefixes combine, so E0 F0 xx is an extended release. Keyboard replies (self-test passed 0xAA, acknowledge 0xFA, echo 0xEE) leave on a separate status strobe. A frame with a bad parity or stop bit raises an error pulse and drops any prefix seen so far. A frame that stalls in the middle is abandoned after a programmable idle time.

Top module: `ps2_key_decoder`

## Requirements
- R1: A frame carries a 0 start bit, 8 data bits LSB first, an odd parity bit and a 1 stop bit, each sampled at a falling keyboard-clock edge. A good frame holding a byte other than E0, F0, AA, FA or EE gives one key event: `key_valid_o` pulses, `key_code_o` holds the byte, and `key_ext_o` = 0, `key_break_o` = 0.
- R2: F0 followed by a code gives a single event with `key_break_o` = 1 and `key_ext_o` = 0. The F0 byte makes no event of its own.
- R3: E0 followed by a code gives a single event with `key_ext_o` = 1 and `key_break_o` = 0.
- R4: E0, F0, code gives a single event with both `key_ext_o` and `key_break_o` set to 1.
- R5: The prefix flags clear after every key event. Repeated make codes each give a separate make event with both flags 0.
- R6: A frame whose parity is not odd pulses `frame_err_o` and produces no event. It clears any pending prefix, so the next code is reported with both flags 0.
- R7: A frame whose stop bit is 0 pulses `frame_err_o`, produces no event and clears any pending prefix.
- R8: Bytes AA, FA and EE pulse `stat_valid_o` with the byte on `stat_code_o` and produce no key event. A pending prefix survives them.
- R9: If a frame has started and no falling edge arrives for `TIMEOUT_CYC` system cycles, the partial frame is discarded without an error. The next complete frame decodes correctly.
- R10: While `rst_ni` is low, all strobes are 0 and all codes and flags are 0.
- R11: `key_valid_o`, `stat_valid_o` and `frame_err_o` are single-cycle pulses, and no two of them are high in the same cycle.
- R12: A falling edge that samples data = 1 while no frame is open is ignored and does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| ps2_dat_i | input | 1 | Keyboard data line (asynchronous) |
| key_valid_o | output | 1 | One-cycle key event strobe |
| key_code_o | output | 8 | Scan code of the event |
| key_ext_o | output | 1 | Event was preceded by the extended prefix |
| key_break_o | output | 1 | Event is a key release |
| stat_valid_o | output | 1 | One-cycle strobe for a keyboard reply byte |
| stat_code_o | output | 8 | Reply byte (AA, FA or EE) |
| frame_err_o | output | 1 | One-cycle strobe for a parity or stop-bit error |

## Verification
The decoder is driven with plain make codes, single and repeated, then with release, extended and combined extended-release sequences. Each of these must map to exactly one event with a different flag pair. Corrupted frames are placed between a prefix and its code, which shows whether errors really clear the prefix state. Reply bytes are placed in the same position, which shows that they pass a prefix through untouched. A stalled partial frame and a lone clock pulse with the data line high show that the receiver realigns to a frame boundary instead of treating stray edges as data.

// File: rtl/ps2_kd_pkg.sv
package ps2_kd_pkg;
  localparam logic [7:0] PFX_EXT  = 8'hE0;
  localparam logic [7:0] PFX_BRK  = 8'hF0;
  localparam logic [7:0] ST_BAT   = 8'hAA;
  localparam logic [7:0] ST_ACK   = 8'hFA;
  localparam logic [7:0] ST_ECHO  = 8'hEE;
  localparam int unsigned FRAME_BITS = 11;

  function automatic logic is_status(input logic [7:0] b);
    return (b == ST_BAT) || (b == ST_ACK) || (b == ST_ECHO);
  endfunction
endpackage

// File: rtl/ps2_kd_sync.sv
module ps2_kd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic fall_o,
  output logic dat_o
);
  logic [STAGES-1:0] clk_sr, dat_sr;
  logic              clk_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_sr   <= '1;
      dat_sr   <= '1;
      clk_last <= 1'b1;
    end else begin
      clk_sr   <= {clk_sr[STAGES-2:0], ps2_clk_i};
      dat_sr   <= {dat_sr[STAGES-2:0], ps2_dat_i};
      clk_last <= clk_sr[STAGES-1];
    end
  end

  assign fall_o = clk_last & ~clk_sr[STAGES-1];
  assign dat_o  = dat_sr[STAGES-1];
endmodule

// File: rtl/ps2_kd_rx.sv
module ps2_kd_rx
  import ps2_kd_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       err_o
);
  localparam int unsigned CW = $clog2(FRAME_BITS);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);

  logic [CW-1:0] bit_cnt;
  logic [9:0]    sh;
  logic [TW-1:0] idle_cnt;
  logic          par_ok;

  // sh[9] = parity, sh[8:1] = data once the stop bit arrives
  assign par_ok = ^sh[9:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      sh         <= '0;
      idle_cnt   <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      err_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      err_o      <= 1'b0;
      if (fall_i) begin
        idle_cnt <= '0;
        if (bit_cnt == '0) begin
          if (!dat_i) bit_cnt <= CW'(1);
        end else if (bit_cnt == LAST_BIT) begin
          bit_cnt <= '0;
          if (par_ok && dat_i) begin
            byte_vld_o <= 1'b1;
            byte_o     <= sh[8:1];
          end else begin
            err_o <= 1'b1;
          end
        end else begin
          sh      <= {dat_i, sh[9:1]};
          bit_cnt <= bit_cnt + CW'(1);
        end
      end else if (bit_cnt != '0) begin
        if (idle_cnt == TW'(TIMEOUT_CYC - 1)) begin
          bit_cnt  <= '0;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ps2_kd_event.sv
module ps2_kd_event
  import ps2_kd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       err_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_ext_o,
  output logic       key_break_o,
  output logic       stat_valid_o,
  output logic [7:0] stat_code_o,
  output logic       frame_err_o
);
  logic ext_q, brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q        <= 1'b0;
      brk_q        <= 1'b0;
      key_valid_o  <= 1'b0;
      key_code_o   <= '0;
      key_ext_o    <= 1'b0;
      key_break_o  <= 1'b0;
      stat_valid_o <= 1'b0;
      stat_code_o  <= '0;
      frame_err_o  <= 1'b0;
    end else begin
      key_valid_o  <= 1'b0;
      stat_valid_o <= 1'b0;
      frame_err_o  <= err_i;
      if (err_i) begin
        ext_q <= 1'b0;
        brk_q <= 1'b0;
      end else if (byte_vld_i) begin
        if (byte_i == PFX_EXT) begin
          ext_q <= 1'b1;
        end else if (byte_i == PFX_BRK) begin
          brk_q <= 1'b1;
        end else if (is_status(byte_i)) begin
          stat_valid_o <= 1'b1;
          stat_code_o  <= byte_i;
        end else begin
          key_valid_o <= 1'b1;
          key_code_o  <= byte_i;
          key_ext_o   <= ext_q;
          key_break_o <= brk_q;
          ext_q       <= 1'b0;
          brk_q       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 20000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic       key_valid_o,
  output logic [7:0] key_code_o,
  output logic       key_ext_o,
  output logic       key_break_o,
  output logic       stat_valid_o,
  output logic [7:0] stat_code_o,
  output logic       frame_err_o
);
  logic       fall, dat;
  logic       byte_vld, byte_err;
  logic [7:0] byte_val;

  ps2_kd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_dat_i,
    .fall_o(fall), .dat_o(dat)
  );

  ps2_kd_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk_i, .rst_ni, .fall_i(fall), .dat_i(dat),
    .byte_vld_o(byte_vld), .byte_o(byte_val), .err_o(byte_err)
  );

  ps2_kd_event u_evt (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .byte_i(byte_val), .err_i(byte_err),
    .key_valid_o, .key_code_o, .key_ext_o, .key_break_o,
    .stat_valid_o, .stat_code_o, .frame_err_o
  );
endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       key_valid_o,
  input logic [7:0] key_code_o,
  input logic       stat_valid_o,
  input logic [7:0] stat_code_o,
  input logic       frame_err_o
);
  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({key_valid_o, stat_valid_o, frame_err_o}));

  p_key_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  p_err_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);

  p_key_not_special_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> !(key_code_o inside {8'hE0, 8'hF0, 8'hAA, 8'hFA, 8'hEE}));

  p_stat_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> (stat_code_o inside {8'hAA, 8'hFA, 8'hEE}));

  p_stat_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |=> !stat_valid_o);
endmodule

bind ps2_key_decoder ps2_key_decoder_chk u_chk (
  .clk_i, .rst_ni, .key_valid_o, .key_code_o,
  .stat_valid_o, .stat_code_o, .frame_err_o
);

// File: tb/ps2_key_decoder_tb_top.sv
`timescale 1ns/1ps
module ps2_key_decoder_tb_top;
  localparam int HALF = 20;     // keyboard half period in system cycles
  localparam int TMO  = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic kclk = 1'b1, kdat = 1'b1;
  logic key_valid, key_ext, key_break, stat_valid, frame_err;
  logic [7:0] key_code, stat_code;

  always #2.5 clk = ~clk;

  ps2_key_decoder #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
    .key_valid_o(key_valid), .key_code_o(key_code), .key_ext_o(key_ext),
    .key_break_o(key_break), .stat_valid_o(stat_valid), .stat_code_o(stat_code),
    .frame_err_o(frame_err)
  );

  int checks = 0, errors = 0;
  int n_key = 0, n_stat = 0, n_err = 0;
  logic [7:0] l_code, l_stat;
  logic l_ext, l_brk;
  logic prev_kv = 0, prev_sv = 0, prev_fe = 0;
  int bad_pulse = 0, bad_excl = 0;

  always @(negedge clk) if (rst_n) begin
    if (key_valid) begin n_key++; l_code = key_code; l_ext = key_ext; l_brk = key_break; end
    if (stat_valid) begin n_stat++; l_stat = stat_code; end
    if (frame_err) n_err++;
    if ((key_valid && prev_kv) || (stat_valid && prev_sv) || (frame_err && prev_fe)) bad_pulse++;
    if (int'(key_valid) + int'(stat_valid) + int'(frame_err) > 1) bad_excl++;
    prev_kv = key_valid; prev_sv = stat_valid; prev_fe = frame_err;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(logic [10:0] bits, int nbits);
    for (int i = 0; i < nbits; i++) begin
      kdat = bits[i];
      cyc(HALF);
      kclk = 1'b0;
      cyc(HALF);
      kclk = 1'b1;
    end
    kdat = 1'b1;
    cyc(HALF);
  endtask

  task automatic send(logic [7:0] b, bit bad_par = 0, bit bad_stop = 0);
    logic par;
    par = ~^b ^ bad_par;
    send_bits({~bad_stop, par, b, 1'b0}, 11);
    cyc(20);
  endtask

  task automatic expect_key(string req, int k0, logic [7:0] code, logic ext, logic brk);
    check({req, " count"}, n_key - k0, 1);
    check({req, " code"}, l_code, code);
    check({req, " ext"}, l_ext, ext);
    check({req, " brk"}, l_brk, brk);
  endtask

  task automatic t_reset_r10();
    check("R10 key_valid", key_valid, 0);
    check("R10 key_code", key_code, 0);
    check("R10 flags", {key_ext, key_break}, 0);
    check("R10 stat", {stat_valid, stat_code}, 0);
    check("R10 err", frame_err, 0);
  endtask

  task automatic t_make_r1();
    int k0 = n_key, s0 = n_stat;
    send(8'h1C);
    expect_key("R1 make", k0, 8'h1C, 0, 0);
    check("R1 no stat", n_stat - s0, 0);
  endtask

  task automatic t_break_r2();
    int k0 = n_key;
    send(8'hF0); send(8'h1C);
    expect_key("R2 break", k0, 8'h1C, 0, 1);
  endtask

  task automatic t_ext_r3();
    int k0 = n_key;
    send(8'hE0); send(8'h75);
    expect_key("R3 ext make", k0, 8'h75, 1, 0);
  endtask

  task automatic t_ext_break_r4();
    int k0 = n_key;
    send(8'hE0); send(8'hF0); send(8'h14);
    expect_key("R4 ext break", k0, 8'h14, 1, 1);
  endtask

  task automatic t_repeat_r5();
    for (int i = 0; i < 3; i++) begin
      int k0 = n_key;
      send(8'h29);
      expect_key("R5 repeat", k0, 8'h29, 0, 0);
    end
  endtask

  task automatic t_parity_r6();
    int k0, e0;
    send(8'hE0);
    k0 = n_key; e0 = n_err;
    send(8'h33, 1, 0);
    check("R6 err pulse", n_err - e0, 1);
    check("R6 no event", n_key - k0, 0);
    send(8'h33);
    expect_key("R6 prefix cleared", k0, 8'h33, 0, 0);
  endtask

  task automatic t_stop_r7();
    int k0, e0;
    send(8'hF0);
    k0 = n_key; e0 = n_err;
    send(8'h44, 0, 1);
    check("R7 err pulse", n_err - e0, 1);
    check("R7 no event", n_key - k0, 0);
    send(8'h44);
    expect_key("R7 prefix cleared", k0, 8'h44, 0, 0);
  endtask

  task automatic t_status_r8();
    int k0, s0;
    logic [7:0] st [3] = '{8'hAA, 8'hFA, 8'hEE};
    for (int i = 0; i < 3; i++) begin
      s0 = n_stat; k0 = n_key;
      send(st[i]);
      check("R8 stat pulse", n_stat - s0, 1);
      check("R8 stat code", l_stat, st[i]);
      check("R8 no key", n_key - k0, 0);
    end
    k0 = n_key;
    send(8'hE0); send(8'hAA); send(8'h11);
    expect_key("R8 prefix kept", k0, 8'h11, 1, 0);
  endtask

  task automatic t_timeout_r9();
    int k0 = n_key, e0 = n_err;
    send_bits({2'b11, 8'h5A, 1'b0}, 4);
    cyc(TMO + 100);
    send(8'h2B);
    expect_key("R9 after stall", k0, 8'h2B, 0, 0);
    check("R9 no err", n_err - e0, 0);
  endtask

  task automatic t_glitch_r12();
    int k0 = n_key, e0 = n_err;
    send_bits(11'h7FF, 1);
    cyc(20);
    send(8'h1B);
    expect_key("R12 ignored edge", k0, 8'h1B, 0, 0);
    check("R12 no err", n_err - e0, 0);
  endtask

  initial begin
    cyc(5);
    t_reset_r10();
    rst_n = 1'b1;
    cyc(5);
    t_make_r1();
    t_break_r2();
    t_ext_r3();
    t_ext_break_r4();
    t_repeat_r5();
    t_parity_r6();
    t_stop_r7();
    t_status_r8();
    t_timeout_r9();
    t_glitch_r12();
    check("R11 pulse width", bad_pulse, 0);
    check("R11 exclusive", bad_excl, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule